// File: doc/BRIEF.md
# Priority Interrupt Controller with Save/Restore Stack

This block arbitrates a set of peripheral interrupt request lines for a single processor. Every source has a programmable priority and a fixed vector number, equal to a base value plus the source index. The controller raises one request toward the processor whenever the best pending source outranks the running priority. The running priority is held in a register that software may rewrite at any moment.

Acknowledging an interrupt does two things. It saves the running priority on a hardware last-in/first-out stack, and it raises the running priority to the level of the source being serviced. An end-of-interrupt write pops the saved level back. A level that a handler raised for itself therefore survives a nested preemption. Acknowledge comes either from a register read (software vector mode) or from a strobe pin (hardware vector mode). A small word-addressed register bus gives access to the running priority, the vector, end-of-interrupt and the per-source priorities.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `irq_req` is high in the same cycle exactly when at least one asserted source has a nonzero priority strictly greater than the running priority.
- R2: The selected source is the asserted one with the highest priority, and equal priorities go to the lower index. Priority 0 disables a source. Its vector is VEC_BASE plus its index (default base 32).
- R3: The vector (read at word 1, driven on `vec_out`) and its priority are captured on every clock edge where `irq_req` is high. They hold while `irq_req` is low. Both are 0 after reset.
- R4: A bus write to word 0 loads bits [3:0] into the running priority. The new value reads back at word 0 from the next cycle.
- R5: In software mode (`hw_mode`=0), a bus read of word 1 acknowledges. It pushes the running priority and loads the captured priority. This also happens when software has raised the level so that `irq_req` has already fallen.
- R6: In hardware mode (`hw_mode`=1), a one-cycle `vec_ack` pulse acknowledges, with the same effect as R5. A read of word 1 then has no side effect.
- R7: A bus write to word 2 pops the top stack entry into the running priority. The write data is ignored.
- R8: A source that deasserts leaves arbitration in the same cycle.
- R9: The stack holds 15 entries. An acknowledge when it is full changes neither the stack nor the running priority. An end-of-interrupt when it is empty changes nothing. Either case sets `lifo_err`, which stays set until reset.
- R10: `irq_req` falls in the cycle after an acknowledge unless another pending source outranks the new running priority.
- R11: Words 8 to 15 read and write the priorities of sources 0 to 7 in bits [3:0]. Words 2 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_mode | input | 1 | 1 selects hardware vector mode |
| irq_src | input | 8 | Peripheral request lines, one per source |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq_req | output | 1 | Interrupt request to processor |
| vec_out | output | 8 | Captured vector |
| vec_ack | input | 1 | Acknowledge strobe in hardware mode |
| lifo_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The hardest case to reach is an acknowledge that arrives after software has raised its own level above the pending source. At that point the request line is already low, but the captured vector must still be serviced and the raised level pushed. The bench reaches it by asserting a second source, waiting one edge so the vector is captured, and writing a higher running priority. It then issues the acknowledge read and checks the returned vector, the loaded level and, after the nested end-of-interrupt, the restored raised level. Stack overflow is reached by 15 acknowledges in hardware mode, each from a level written just before it. The pops that follow must return those levels in reverse order.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC     = 8,
  parameter int PW       = 4,
  parameter int DEPTH    = 15,
  parameter int VW       = 8,
  parameter int VEC_BASE = 32,
  parameter int AW       = 4,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_mode,
  input  logic [NSRC-1:0] irq_src,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_req,
  output logic [VW-1:0] vec_out,
  input  logic          vec_ack,
  output logic          lifo_err
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [AW-1:0] PRI_BASE = AW'(2 ** (AW - 1));

  logic [PW-1:0] src_pri [NSRC];
  logic [PW-1:0] stack_q [DEPTH];
  logic [PW-1:0] cur_pri_q, vpri_q, win_pri;
  logic [IW-1:0] win_idx;
  logic [VW-1:0] vec_q;
  logic [CW-1:0] depth_q;
  logic          err_q;

  wire unused_bits = &{1'b0, bus_wdata};

  always_comb begin
    win_pri = '0;
    win_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (irq_src[i] && src_pri[i] > win_pri) begin
        win_pri = src_pri[i];
        win_idx = IW'(i);
      end
  end

  assign irq_req  = win_pri > cur_pri_q;
  assign vec_out  = vec_q;
  assign lifo_err = err_q;

  wire rd_cyc   = bus_sel && !bus_wr;
  wire wr_cyc   = bus_sel && bus_wr;
  wire ack      = hw_mode ? vec_ack : (rd_cyc && bus_addr == AW'(1));
  wire eoi      = wr_cyc && bus_addr == AW'(2);
  wire cpr_wr   = wr_cyc && bus_addr == AW'(0);
  wire pri_hit  = bus_addr >= PRI_BASE && (bus_addr - PRI_BASE) < AW'(NSRC);
  wire [IW-1:0] pri_idx = IW'(bus_addr - PRI_BASE);
  wire full     = depth_q == CW'(DEPTH);
  wire empty    = depth_q == '0;
  wire push     = ack && !full;
  wire pop      = !ack && eoi && !empty;
  wire [CW-1:0] top_idx = depth_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_pri_q <= '0;
      vpri_q    <= '0;
      vec_q     <= '0;
      depth_q   <= '0;
      err_q     <= 1'b0;
      for (int i = 0; i < NSRC; i++) src_pri[i] <= '0;
    end else begin
      if (irq_req) begin
        vec_q  <= VW'(VEC_BASE) + VW'(win_idx);
        vpri_q <= win_pri;
      end
      if (ack) begin
        if (full) err_q <= 1'b1;
        else begin
          depth_q   <= depth_q + 1'b1;
          cur_pri_q <= vpri_q;
        end
      end else if (eoi) begin
        if (empty) err_q <= 1'b1;
        else begin
          depth_q   <= top_idx;
          cur_pri_q <= stack_q[top_idx];
        end
      end else if (cpr_wr) begin
        cur_pri_q <= bus_wdata[PW-1:0];
      end
      if (wr_cyc && pri_hit) src_pri[pri_idx] <= bus_wdata[PW-1:0];
    end
  end

  always_ff @(posedge clk)
    if (rst_n && push) stack_q[depth_q] <= cur_pri_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(0))      bus_rdata = DW'(cur_pri_q);
    else if (bus_addr == AW'(1)) bus_rdata = DW'(vec_q);
    else if (pri_hit)            bus_rdata = DW'(src_pri[pri_idx]);
  end

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src == '0) |-> !irq_req);
  assert_cpr_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpr_wr && !ack) |=> cur_pri_q == $past(bus_wdata[PW-1:0]));
  assert_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !full) |=> (depth_q == $past(depth_q) + 1'b1) && (cur_pri_q == $past(vpri_q)));
  assert_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && !empty) |=> depth_q == $past(depth_q) - 1'b1);
  assert_full_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && full) |=> $stable(cur_pri_q) && $stable(depth_q) && err_q);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_depth_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= CW'(DEPTH));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic       clk = 0, rst_n = 0, hw_mode = 0, bus_sel = 0, bus_wr = 0, vec_ack = 0;
  logic [7:0] irq_src = 0, bus_wdata = 0, bus_rdata, vec_out;
  logic [3:0] bus_addr = 0;
  logic       irq_req, lifo_err;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .irq_src(irq_src),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .vec_out(vec_out),
    .vec_ack(vec_ack), .lifo_err(lifo_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0; irq_src = 0; vec_ack = 0;
    tick; tick; rst_n = 1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    tick;
    bus_sel = 0;
  endtask

  task automatic ack_pulse;
    vec_ack = 1; tick; vec_ack = 0;
  endtask

  int pri_m [8];
  int model_vec;
  logic [7:0] d;

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset;
    #1;
    chk("R1 reset irq_req", irq_req, 0);
    chk("R9 reset lifo_err", lifo_err, 0);
    rd(0, d); chk("R4 reset running priority", d, 0);
    rd(1, d); chk("R3 reset vector", d, 0);

    // R11 priority readback and unused words
    for (int i = 0; i < 8; i++) begin
      wr(4'(8 + i), 8'(8'hF0 | ((i * 7 + 3) % 16)));
      rd(4'(8 + i), d); chk("R11 priority readback", d, (i * 7 + 3) % 16);
    end
    for (int a = 2; a < 8; a++) begin rd(4'(a), d); chk("R11 unused word", d, 0); end

    // R1/R2/R3/R8 sweep in hardware mode (word 1 reads unused here)
    hw_mode = 1;
    model_vec = 0;
    for (int cfg = 0; cfg < 2; cfg++) begin
      irq_src = 0;
      for (int i = 0; i < 8; i++) begin
        pri_m[i] = (cfg == 0) ? ((i == 1) ? 0 : (i * 5 + 3) % 16) : ((i % 3 == 0) ? 9 : i);
        wr(4'(8 + i), 8'(pri_m[i]));
      end
      for (int c = 0; c < 3; c++) begin
        irq_src = 0;
        wr(0, 8'(c * 7));
        for (int p = 0; p < 256; p++) begin
          int wp, wi;
          irq_src = 8'(p);
          wp = 0; wi = 0;
          for (int i = 0; i < 8; i++)
            if (p[i] && pri_m[i] > wp) begin wp = pri_m[i]; wi = i; end
          #1 chk("R1 R2 R8 request", irq_req, (wp > c * 7) ? 1 : 0);
          if (wp > c * 7) model_vec = 32 + wi;
          @(posedge clk); #1;
          chk("R2 R3 captured vector", vec_out, model_vec);
          @(negedge clk);
        end
      end
    end
    irq_src = 0;

    // Software mode nesting with raised priority
    do_reset;
    hw_mode = 0;
    wr(9, 1); wr(10, 2);
    irq_src = 8'b0000_0010; tick;
    chk("R1 source 1 preempts level 0", irq_req, 1);
    rd(1, d); chk("R5 acknowledge vector", d, 33);
    #1 chk("R10 request falls after ack", irq_req, 0);
    rd(0, d); chk("R5 level loaded", d, 1);
    irq_src = 8'b0000_0110; tick;
    chk("R1 source 2 preempts level 1", irq_req, 1);
    wr(0, 3);
    #1 chk("R4 raise hides request", irq_req, 0);
    rd(0, d); chk("R4 raised level", d, 3);
    rd(1, d); chk("R5 late acknowledge vector", d, 34);
    rd(0, d); chk("R5 level after late ack", d, 2);
    irq_src = 8'b0000_0010; #1;
    chk("R8 dropped source", irq_req, 0);
    wr(2, 8'hA5); rd(0, d); chk("R7 raised level restored", d, 3);
    wr(2, 8'h00); rd(0, d); chk("R7 second pop", d, 0);
    chk("R9 no error yet", lifo_err, 0);
    wr(2, 8'h00); rd(0, d); chk("R9 empty pop keeps level", d, 0);
    chk("R9 underflow flag", lifo_err, 1);
    tick; chk("R9 flag sticky", lifo_err, 1);

    // Hardware mode: read has no side effect, overflow, ordered pops
    do_reset;
    hw_mode = 1;
    wr(8, 15);
    irq_src = 8'b0000_0001; tick;
    chk("R6 vector on pin", vec_out, 32);
    rd(1, d); chk("R6 word 1 readable", d, 32);
    rd(0, d); chk("R6 read has no side effect", d, 0);
    chk("R6 request still high", irq_req, 1);
    for (int i = 0; i < 15; i++) begin
      wr(0, 8'(i)); tick;
      ack_pulse;
      rd(0, d); chk("R6 strobe loads level", d, 15);
      chk("R10 request low", irq_req, 0);
    end
    chk("R9 full stack no error", lifo_err, 0);
    wr(0, 5); tick;
    ack_pulse;
    rd(0, d); chk("R9 overflow keeps level", d, 5);
    chk("R9 overflow flag", lifo_err, 1);
    for (int j = 14; j >= 0; j--) begin
      wr(2, 8'hFF); rd(0, d); chk("R7 ordered pop", d, j);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule